// File: doc/BRIEF.md
# Stack Expression Evaluator with Register-Cached Top

This block evaluates arithmetic in postfix form. A stream of commands arrives over a valid/ready handshake. Each command pushes an operand, pops the top, or applies one of four binary operations: add, subtract, multiply or divide. A binary operation names no operands. It always takes the two uppermost stack entries and leaves one result in their place. After every command, the current top of the stack is visible on the outputs.

Only the uppermost `N` entries sit in fast registers. Deeper entries live in a backing memory, reached through a simple request/acknowledge port. A push onto a full register set first writes the deepest register entry out to memory. When the register set holds fewer than `N` entries and memory is not empty, the block reads one entry back before it accepts the next command. Two counters record the number of memory stores and fetches, so the cost of a given cache depth can be measured directly.

Top module: `stk_eval`

## Requirements
- R1: After reset the stack is empty (`top_valid` low), `cmd_ready` is high, both traffic counters are zero, both error flags are low and `mem_req` is low.
- R2: Push places `cmd_data` on top and pop removes the top entry. Entries return in last-in, first-out order, and `top_data` always shows the current top.
- R3: A binary operation replaces the top two entries with one result. The entry below the top is the left operand and the top entry is the right operand. Add and subtract wrap modulo 2^W, multiply keeps the low W bits, and divide returns the unsigned quotient.
- R4: `cmd_op` encodes push=0, pop=1, add=2, subtract=3, multiply=4, divide=5. Codes 6 and 7 are accepted and leave the stack, the flags and the counters unchanged.
- R5: A push made while all `N` registers are occupied first writes the deepest register entry to memory address equal to the current memory depth (first spill to address 0). Only after that write is the new value placed on top.
- R6: Whenever fewer than `N` registers are occupied and memory holds entries, the block reads the entry at address memory-depth-minus-one into the deepest register slot. It does this before accepting another command.
- R7: `cmd_ready` is low while a memory access is pending. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`.
- R8: `store_count` increments once per completed memory write and `fetch_count` once per completed memory read. With `N`=2, the postfix sequence a b c * + a d c * + e - / ends with 4 stores, 4 fetches, and the correct result on top.
- R9: With `N`=4, the same sequence ends with zero stores, zero fetches and the same result.
- R10: A pop on an empty stack, or a binary operation with fewer than two entries, sets the sticky `err_stack` flag. The stack is left unchanged.
- R11: A divide whose right operand is zero produces an all-ones result and sets the sticky `err_div0` flag.
- R12: A push made when both the registers and the backing memory (`MEM_DEPTH` entries) are full sets `err_stack`. The push is dropped and the stack is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code |
| cmd_data | input | W | Operand for push |
| top_valid | output | 1 | Stack is not empty |
| top_data | output | W | Value on top of the stack |
| err_stack | output | 1 | Sticky underflow / capacity error |
| err_div0 | output | 1 | Sticky divide-by-zero error |
| mem_req | output | 1 | Backing memory access pending |
| mem_we | output | 1 | Access is a write (spill) |
| mem_addr | output | $clog2(MEM_DEPTH) | Backing memory address |
| mem_wdata | output | W | Spilled value |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | W | Read data for a fill |
| store_count | output | CNT_W | Completed memory writes |
| fetch_count | output | CNT_W | Completed memory reads |

## Verification
Some properties are checked by assertions on every cycle:
- a spill only happens with a full register set;
- the memory request stays stable until acknowledged, and the command side is stalled while it is pending;
- the block never offers `cmd_ready` while a fill is owed;
- both error flags stay set once raised;
- a binary operation never reaches the register set with fewer than two entries;
- the store counter steps exactly on acknowledged writes.

Other behaviour can only be shown by the bench's scenarios:
- the values of results and operand order;
- the exact store and fetch totals for the reference expression at two cache depths;
- the spilled data landing at the right address;
- last-in, first-out recovery through a full backing memory;
- the handling of unused codes and capacity overflow.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5
  } stk_op_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_PUSH,
    ACT_POP,
    ACT_BIN,
    ACT_FILL
  } stk_act_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPILL,
    ST_FILL
  } stk_state_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res,
  output logic         div0
);
  always_comb begin
    div0 = (op == OP_DIV) && (rhs == '0);
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = lhs * rhs;
      OP_DIV:  res = div0 ? '1 : lhs / rhs;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/stk_cache.sv
module stk_cache
  import stk_pkg::*;
#(
  parameter int N = 2,
  parameter int W = 16,
  localparam int RCW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  stk_act_e       act,
  input  logic [W-1:0]   push_val,
  input  logic [W-1:0]   bin_val,
  input  logic [W-1:0]   fill_val,
  output logic [W-1:0]   top,
  output logic [W-1:0]   second,
  output logic [W-1:0]   deepest,
  output logic [RCW-1:0] cnt
);
  logic [W-1:0]   ent_q [N];
  logic [W-1:0]   ent_d [N];
  logic [RCW-1:0] cnt_q, cnt_d;
  logic           ent_en;

  assign ent_en = (act != ACT_NONE);

  // Entry 0 is the top; entry cnt_q-1 is the deepest occupied slot.
  for (genvar i = 0; i < N; i++) begin : g_ent
    always_comb begin
      ent_d[i] = ent_q[i];
      case (act)
        ACT_PUSH: begin
          if (i == 0) ent_d[i] = push_val;
          else        ent_d[i] = ent_q[(i == 0) ? 0 : i - 1];
        end
        ACT_POP: begin
          if (i < N - 1) ent_d[i] = ent_q[(i < N - 1) ? i + 1 : i];
        end
        ACT_BIN: begin
          if (i == 0)         ent_d[i] = bin_val;
          else if (i < N - 1) ent_d[i] = ent_q[(i < N - 1) ? i + 1 : i];
        end
        ACT_FILL: begin
          if (cnt_q == RCW'(i)) ent_d[i] = fill_val;
        end
        default: ent_d[i] = ent_q[i];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[i] <= '0;
      else if (ent_en) ent_q[i] <= ent_d[i];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    case (act)
      ACT_PUSH: if (cnt_q != RCW'(N)) cnt_d = cnt_q + 1'b1;
      ACT_POP,
      ACT_BIN:  cnt_d = cnt_q - 1'b1;
      ACT_FILL: cnt_d = cnt_q + 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (ent_en) cnt_q <= cnt_d;
  end

  assign top     = ent_q[0];
  assign second  = ent_q[1];
  assign deepest = ent_q[N-1];
  assign cnt     = cnt_q;

  AST_CACHE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RCW'(N)); // R5
  AST_BIN_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_BIN) |-> (cnt_q >= RCW'(2))); // R10
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_POP) |-> (cnt_q != '0)); // R10
endmodule

// File: rtl/stk_eval.sv
module stk_eval
  import stk_pkg::*;
#(
  parameter int N         = 2,
  parameter int W         = 16,
  parameter int MEM_DEPTH = 16,
  parameter int CNT_W     = 16,
  localparam int AW  = $clog2(MEM_DEPTH),
  localparam int MCW = $clog2(MEM_DEPTH + 1),
  localparam int RCW = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [W-1:0]     cmd_data,
  output logic             top_valid,
  output logic [W-1:0]     top_data,
  output logic             err_stack,
  output logic             err_div0,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic             mem_ack,
  input  logic [W-1:0]     mem_rdata,
  output logic [CNT_W-1:0] store_count,
  output logic [CNT_W-1:0] fetch_count
);
  stk_state_e       state_q, state_d;
  logic [MCW-1:0]   mcnt_q, mcnt_d;
  logic [W-1:0]     pend_q, pend_d;
  logic [CNT_W-1:0] store_q, store_d, fetch_q, fetch_d;
  logic             errs_q, errs_d, errz_q, errz_d;
  logic             reg_en;

  stk_act_e         act;
  logic [W-1:0]     push_val, top_w, second_w, deepest_w, alu_res;
  logic [RCW-1:0]   reg_cnt;
  logic             alu_div0, need_fill, accept, is_bin;

  stk_cache #(.N(N), .W(W)) u_cache (
    .clk(clk), .rst_n(rst_n), .act(act), .push_val(push_val),
    .bin_val(alu_res), .fill_val(mem_rdata), .top(top_w),
    .second(second_w), .deepest(deepest_w), .cnt(reg_cnt)
  );

  stk_alu #(.W(W)) u_alu (
    .op(cmd_op), .lhs(second_w), .rhs(top_w), .res(alu_res), .div0(alu_div0)
  );

  assign need_fill = (reg_cnt < RCW'(N)) && (mcnt_q != '0);
  assign cmd_ready = (state_q == ST_IDLE) && !need_fill;
  assign accept    = cmd_valid && cmd_ready;
  assign is_bin    = (cmd_op >= OP_ADD) && (cmd_op <= OP_DIV);

  always_comb begin
    state_d  = state_q;
    mcnt_d   = mcnt_q;
    pend_d   = pend_q;
    store_d  = store_q;
    fetch_d  = fetch_q;
    errs_d   = errs_q;
    errz_d   = errz_q;
    act      = ACT_NONE;
    push_val = cmd_data;
    case (state_q)
      ST_IDLE: begin
        if (need_fill) begin
          state_d = ST_FILL;
        end else if (accept) begin
          if (cmd_op == OP_PUSH) begin
            if (reg_cnt != RCW'(N)) begin
              act = ACT_PUSH;
            end else if (mcnt_q == MCW'(MEM_DEPTH)) begin
              errs_d = 1'b1;
            end else begin
              pend_d  = cmd_data;
              state_d = ST_SPILL;
            end
          end else if (cmd_op == OP_POP) begin
            if (reg_cnt == '0) errs_d = 1'b1;
            else               act = ACT_POP;
          end else if (is_bin) begin
            if (reg_cnt < RCW'(2)) begin
              errs_d = 1'b1;
            end else begin
              act = ACT_BIN;
              if (alu_div0) errz_d = 1'b1;
            end
          end
        end
      end
      ST_SPILL: begin
        if (mem_ack) begin
          act      = ACT_PUSH;
          push_val = pend_q;
          mcnt_d   = mcnt_q + 1'b1;
          store_d  = store_q + 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          act     = ACT_FILL;
          mcnt_d  = mcnt_q - 1'b1;
          fetch_d = fetch_q + 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign reg_en = (state_q != ST_IDLE) || need_fill || accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mcnt_q  <= '0;
      pend_q  <= '0;
      store_q <= '0;
      fetch_q <= '0;
      errs_q  <= 1'b0;
      errz_q  <= 1'b0;
    end else if (reg_en) begin
      state_q <= state_d;
      mcnt_q  <= mcnt_d;
      pend_q  <= pend_d;
      store_q <= store_d;
      fetch_q <= fetch_d;
      errs_q  <= errs_d;
      errz_q  <= errz_d;
    end
  end

  assign mem_req     = (state_q != ST_IDLE);
  assign mem_we      = (state_q == ST_SPILL);
  assign mem_addr    = (state_q == ST_SPILL) ? AW'(mcnt_q) : AW'(mcnt_q - 1'b1);
  assign mem_wdata   = deepest_w;
  assign top_valid   = (reg_cnt != '0);
  assign top_data    = top_w;
  assign err_stack   = errs_q;
  assign err_div0    = errz_q;
  assign store_count = store_q;
  assign fetch_count = fetch_q;

  AST_SPILL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (reg_cnt == RCW'(N))); // R5
  AST_READY_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> ((mcnt_q == '0) || (reg_cnt == RCW'(N)))); // R6
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R7
  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cmd_ready); // R7
  AST_STORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (store_count == $past(store_count) + 1'b1)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_stack |=> err_stack); // R10
  AST_DIV0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_div0 |=> err_div0); // R11
endmodule

// File: tb/stk_mem_model.sv
module stk_mem_model #(
  parameter int W   = 16,
  parameter int AW  = 4,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic          ack,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [2**AW];
  int wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack      <= 1'b0;
      rdata    <= '0;
      wait_cnt <= 0;
    end else if (req && !ack) begin
      if (wait_cnt == LAT - 1) begin
        ack      <= 1'b1;
        rdata    <= mem[addr];
        wait_cnt <= 0;
        if (we) mem[addr] <= wdata;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      ack      <= 1'b0;
      wait_cnt <= 0;
    end
  end
endmodule

// File: tb/stk_eval_tb.sv
module stk_eval_tb;
  localparam int W  = 16;
  localparam int MD = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          sel = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [W-1:0]  cmd_data = '0;

  logic          rdy2, rdy4, tv2, tv4, es2, es4, ez2, ez4;
  logic [W-1:0]  td2, td4, wd2, wd4, rd2, rd4;
  logic          rq2, rq4, we2, we4, ak2, ak4;
  logic [AW-1:0] ad2, ad4;
  logic [15:0]   sc2, sc4, fc2, fc4;

  stk_eval #(.N(2), .W(W), .MEM_DEPTH(MD), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid && !sel), .cmd_ready(rdy2),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .top_valid(tv2), .top_data(td2),
    .err_stack(es2), .err_div0(ez2), .mem_req(rq2), .mem_we(we2),
    .mem_addr(ad2), .mem_wdata(wd2), .mem_ack(ak2), .mem_rdata(rd2),
    .store_count(sc2), .fetch_count(fc2)
  );
  stk_mem_model #(.W(W), .AW(AW), .LAT(2)) u_mem2 (
    .clk(clk), .rst_n(rst_n), .req(rq2), .we(we2), .addr(ad2),
    .wdata(wd2), .ack(ak2), .rdata(rd2)
  );

  stk_eval #(.N(4), .W(W), .MEM_DEPTH(MD), .CNT_W(16)) u_dut4 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid && sel), .cmd_ready(rdy4),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .top_valid(tv4), .top_data(td4),
    .err_stack(es4), .err_div0(ez4), .mem_req(rq4), .mem_we(we4),
    .mem_addr(ad4), .mem_wdata(wd4), .mem_ack(ak4), .mem_rdata(rd4),
    .store_count(sc4), .fetch_count(fc4)
  );
  stk_mem_model #(.W(W), .AW(AW), .LAT(2)) u_mem4 (
    .clk(clk), .rst_n(rst_n), .req(rq4), .we(we4), .addr(ad4),
    .wdata(wd4), .ack(ak4), .rdata(rd4)
  );

  wire          c_rdy = sel ? rdy4 : rdy2;
  wire          c_tv  = sel ? tv4 : tv2;
  wire [W-1:0]  c_td  = sel ? td4 : td2;
  wire          c_es  = sel ? es4 : es2;
  wire          c_ez  = sel ? ez4 : ez2;
  wire [15:0]   c_sc  = sel ? sc4 : sc2;
  wire [15:0]   c_fc  = sel ? fc4 : fc2;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference stack model and scoreboard queues
  logic [W-1:0] model[$];
  bit           exp_v[$];
  logic [W-1:0] exp_d[$];
  string        exp_t[$];
  bit           await_done = 1'b0;

  always @(negedge clk) begin
    if (await_done && c_rdy && exp_v.size() > 0) begin
      automatic bit           ev = exp_v.pop_front();
      automatic logic [W-1:0] ed = exp_d.pop_front();
      automatic string        et = exp_t.pop_front();
      chk(c_tv == ev, {et, " top_valid"}, int'(c_tv), int'(ev));
      if (ev) chk(c_td == ed, {et, " top_data"}, int'(c_td), int'(ed));
      await_done = 1'b0;
    end
  end

  task automatic model_step(input logic [2:0] op, input logic [W-1:0] d);
    automatic int cap = (sel ? 4 : 2) + MD;
    logic [W-1:0] a, b;
    case (op)
      3'd0: if (model.size() < cap) model.push_back(d);
      3'd1: if (model.size() > 0) void'(model.pop_back());
      3'd2, 3'd3, 3'd4, 3'd5: begin
        if (model.size() >= 2) begin
          b = model.pop_back();
          a = model.pop_back();
          case (op)
            3'd2: model.push_back(a + b);
            3'd3: model.push_back(a - b);
            3'd4: model.push_back(a * b);
            default: model.push_back((b == 0) ? '1 : a / b);
          endcase
        end
      end
      default: ;
    endcase
  endtask

  task automatic send(input logic [2:0] op, input logic [W-1:0] d, input string tag);
    model_step(op, d);
    exp_v.push_back(model.size() > 0);
    exp_d.push_back(model.size() > 0 ? model[$] : '0);
    exp_t.push_back(tag);
    while (!c_rdy) @(negedge clk);
    cmd_op = op;
    cmd_data = d;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    await_done = 1'b1;
    while (await_done) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_expr(input string tag);
    send(0, 7, tag); send(0, 3, tag); send(0, 5, tag); send(4, 0, tag);
    send(2, 0, tag); send(0, 7, tag); send(0, 2, tag); send(0, 5, tag);
    send(4, 0, tag); send(2, 0, tag); send(0, 4, tag); send(3, 0, tag);
    send(5, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of both instances
    chk(!tv2 && !tv4, "R1 empty", int'(tv2 | tv4), 0);
    chk(rdy2 && rdy4, "R1 ready", int'(rdy2 & rdy4), 1);
    chk(sc2 == 0 && fc2 == 0 && sc4 == 0 && fc4 == 0, "R1 counters", int'(sc2 + fc2 + sc4 + fc4), 0);
    chk(!es2 && !ez2 && !es4 && !ez4, "R1 errors", int'(es2 | ez2 | es4 | ez4), 0);
    chk(!rq2 && !rq4, "R1 mem_req", int'(rq2 | rq4), 0);

    // R10: pop on empty stack
    send(1, 0, "R10 pop empty");
    chk(es2 == 1'b1, "R10 err_stack", int'(es2), 1);
    do_reset();

    // R8: reference expression with two cached entries (R2 R3 R5 R6 via scoreboard)
    run_expr("R8 expr N2");
    chk(sc2 == 4, "R8 stores N2", int'(sc2), 4);
    chk(fc2 == 4, "R8 fetches N2", int'(fc2), 4);
    chk(td2 == 1, "R8 result", int'(td2), 1);

    // R9: same expression with four cached entries
    sel = 1'b1;
    run_expr("R9 expr N4");
    chk(sc4 == 0 && fc4 == 0, "R9 no traffic", int'(sc4 + fc4), 0);
    chk(td4 == 1, "R9 result", int'(td4), 1);
    sel = 1'b0;
    do_reset();

    // R3 operand order and arithmetic, R4 unused codes, R11 divide by zero
    send(0, 10, "R2 push"); send(0, 3, "R2 push"); send(3, 0, "R3 sub order");
    send(0, 20, "R2 push"); send(0, 4, "R2 push"); send(5, 0, "R3 div order");
    send(4, 0, "R3 mul");
    send(0, 16'hFFFF, "R2 push"); send(0, 2, "R2 push"); send(4, 0, "R3 mul wrap");
    send(2, 0, "R3 add wrap");
    send(6, 0, "R4 code6"); send(7, 123, "R4 code7");
    chk(!es2 && !ez2, "R4 flags unchanged", int'(es2 | ez2), 0);
    send(0, 0, "R2 push"); send(5, 0, "R11 div zero");
    chk(td2 == 16'hFFFF, "R11 all ones", int'(td2), 16'hFFFF);
    chk(ez2 == 1'b1, "R11 err_div0", int'(ez2), 1);
    chk(es2 == 1'b0, "R11 no stack err", int'(es2), 0);
    send(1, 0, "R2 pop");
    send(0, 9, "R2 push");
    send(2, 0, "R10 add one entry");
    chk(es2 == 1'b1, "R10 err_stack bin", int'(es2), 1);
    do_reset();

    // R5/R7: spill of deepest entry, stall while pending
    send(0, 1, "R2 push"); send(0, 2, "R2 push");
    while (!rdy2) @(negedge clk);
    cmd_op = 0; cmd_data = 3; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_step(0, 3);
    chk(!rdy2 && rq2 && we2, "R7 stall during spill", int'({rdy2, rq2, we2}), 3);
    chk(ad2 == 0 && wd2 == 1, "R5 spill addr/data", int'({ad2, wd2}), 1);
    while (!rdy2) @(negedge clk);
    chk(u_mem2.mem[0] == 1, "R5 spilled value", int'(u_mem2.mem[0]), 1);
    chk(td2 == 3 && sc2 == 1, "R5 push after spill", int'(td2), 3);

    for (int i = 4; i <= 18; i++) send(0, W'(i), "R5 push spill");
    chk(sc2 == 16, "R8 stores full", int'(sc2), 16);
    chk(es2 == 1'b0, "R12 no error yet", int'(es2), 0);
    send(0, 99, "R12 overflow push");
    chk(es2 == 1'b1, "R12 err_stack", int'(es2), 1);
    chk(sc2 == 16, "R12 no extra store", int'(sc2), 16);
    for (int i = 0; i < 17; i++) send(1, 0, "R6 pop refill");
    chk(fc2 == 16, "R6 fetch total", int'(fc2), 16);
    chk(tv2 && td2 == 1, "R6 bottom value", int'(td2), 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule